// File: doc/BRIEF.md
# Shared-Level Interrupt Latch Selector

This block holds the pending flags for three interrupt priority levels, each shared by two peripheral sources. A select register stores one bit per shared level. That bit decides which of the two sources may set the level's latch. A request pulse from the source that is not selected is thrown away. It is not stored and cannot show up later.

A latch that has been set stays set until one of three things happens: the acceptance sequencer clears it, software clears it, or reset clears it. The pending bits go to a downstream arbiter, ordered by priority. The select register is written and read back through a simple byte-wide port.

Top module: `shared_irq_latch_sel`

## Requirements
- R1: After reset, `pending` is 3'b000 and `sel_rdata` is 8'h00.
- R2: A write stores data bit 6 as the level-10 selector, bit 1 as the level-15 selector and bit 0 as the level-16 selector. `sel_rdata` returns those bits in the same positions, and every other bit reads 0.
- R3: Latch order: `pending[0]` is the level-10 latch (serial receive or serial I/O), `pending[1]` is the level-15 latch (external input 3 or timer 3) and `pending[2]` is the level-16 latch (external input 5 or timer 5).
- R4: Select value 0 lets `req_first[i]` set latch i, and value 1 lets `req_second[i]` set it. The latch reads 1 on the first sample after the clock edge that captured the one-cycle pulse.
- R5: A pulse from the unselected source of a pair leaves that latch at 0. Switching the select bit afterwards does not raise the latch.
- R6: A set latch stays at 1 while neither clear input for it is asserted.
- R7: `ack_clr[i]` clears latch i at the next clock edge.
- R8: `sw_clr[i]` clears latch i at the next clock edge.
- R9: If a selected request and a clear for the same latch arrive in the same cycle, the latch ends at 1.
- R10: Writing a new select value does not clear a latch that is already pending.
- R11: Without a write, the select register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_first | input | 3 | One-cycle request pulses from the first source of each pair |
| req_second | input | 3 | One-cycle request pulses from the second source of each pair |
| ack_clr | input | 3 | Per-latch clear from the acceptance sequencer |
| sw_clr | input | 3 | Per-latch clear from software |
| sel_we | input | 1 | Select register write strobe |
| sel_wdata | input | 8 | Select register write data |
| sel_rdata | output | 8 | Select register readback |
| pending | output | 3 | Pending latches, priority order |

## Verification
Every result takes exactly one register stage. A request, a clear or a select write presented before a rising edge is visible on `pending` or `sel_rdata` right after that edge. The bench drives inputs on the falling edge and samples on the next falling edge, half a period after the capturing edge. To show that a dropped request leaves no trace, the bench flips the select bit and samples again over several cycles.

// File: rtl/shared_irq_latch_sel.sv
module shared_irq_latch_sel #(
  parameter int NLVL = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NLVL-1:0] req_first,
  input  logic [NLVL-1:0] req_second,
  input  logic [NLVL-1:0] ack_clr,
  input  logic [NLVL-1:0] sw_clr,
  input  logic            sel_we,
  input  logic [7:0]      sel_wdata,
  output logic [7:0]      sel_rdata,
  output logic [NLVL-1:0] pending
);

  logic [NLVL-1:0] sel_q, pend_q;
  logic [NLVL-1:0] gated, clr;

  assign gated = (req_first & ~sel_q) | (req_second & sel_q);
  assign clr   = ack_clr | sw_clr;

  always_ff @(posedge clk) begin
    if (!rst_n) sel_q <= '0;
    else if (sel_we) sel_q <= {sel_wdata[0], sel_wdata[1], sel_wdata[6]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else pend_q <= (pend_q & ~clr) | gated;
  end

  assign sel_rdata = {1'b0, sel_q[0], 4'b0000, sel_q[1], sel_q[2]};
  assign pending   = pend_q;

  assert_sel_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_we |=> $stable(sel_rdata));

  assert_sel_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_we |=> (sel_rdata == ($past(sel_wdata) & 8'h43)));

  for (genvar i = 0; i < NLVL; i++) begin : g_chk
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((req_first[i] && !sel_q[i]) || (req_second[i] && sel_q[i])) |=> pending[i]);

    assert_drop_unsel_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!pending[i] && !(sel_q[i] ? req_second[i] : req_first[i])) |=> !pending[i]);

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pending[i] && !ack_clr[i] && !sw_clr[i]) |=> pending[i]);

    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pending[i] && (ack_clr[i] || sw_clr[i]) && !req_first[i] && !req_second[i]) |=> !pending[i]);
  end

endmodule

// File: tb/test_shared_irq_latch_sel.sv
module test_shared_irq_latch_sel;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [2:0] req_first = 0, req_second = 0, ack_clr = 0, sw_clr = 0;
  logic       sel_we = 0;
  logic [7:0] sel_wdata = 0;
  logic [7:0] sel_rdata;
  logic [2:0] pending;
  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  shared_irq_latch_sel i_shared_irq_latch_sel (
    .clk(clk), .rst_n(rst_n), .req_first(req_first), .req_second(req_second),
    .ack_clr(ack_clr), .sw_clr(sw_clr), .sel_we(sel_we), .sel_wdata(sel_wdata),
    .sel_rdata(sel_rdata), .pending(pending));

  task automatic chk(input string r, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic idle();
    req_first = 0; req_second = 0; ack_clr = 0; sw_clr = 0; sel_we = 0;
  endtask

  task automatic cyc();
    @(negedge clk);
    idle();
  endtask

  task automatic wr_sel(input logic [7:0] d);
    sel_we = 1; sel_wdata = d; cyc();
  endtask

  task automatic clear_all();
    sw_clr = 3'b111; cyc();
  endtask

  task automatic t_reset();
    chk("R1 pending", {5'b0, pending}, 8'h00);
    chk("R1 sel_rdata", sel_rdata, 8'h00);
  endtask

  task automatic t_register();
    wr_sel(8'hFF);
    chk("R2 readback all ones", sel_rdata, 8'h43);
    wr_sel(8'h40);
    chk("R2 bit6 only", sel_rdata, 8'h40);
    wr_sel(8'h02);
    chk("R2 bit1 only", sel_rdata, 8'h02);
    repeat (3) cyc();
    chk("R11 held without write", sel_rdata, 8'h02);
    wr_sel(8'h00);
  endtask

  task automatic t_select_first();
    req_first = 3'b001; cyc();
    chk("R3 R4 level10 first", {5'b0, pending}, 8'h01);
    req_first = 3'b010; cyc();
    chk("R3 R4 level15 first", {5'b0, pending}, 8'h03);
    req_first = 3'b100; cyc();
    chk("R3 R4 level16 first", {5'b0, pending}, 8'h07);
    repeat (4) cyc();
    chk("R6 held", {5'b0, pending}, 8'h07);
    clear_all();
    chk("R8 sw clear all", {5'b0, pending}, 8'h00);
  endtask

  task automatic t_select_second();
    wr_sel(8'h43);
    req_second = 3'b101; cyc();
    chk("R4 second sources", {5'b0, pending}, 8'h05);
    ack_clr = 3'b001; cyc();
    chk("R7 ack clears level10 only", {5'b0, pending}, 8'h04);
    sw_clr = 3'b100; cyc();
    chk("R8 sw clears level16", {5'b0, pending}, 8'h00);
  endtask

  task automatic t_drop();
    wr_sel(8'h00);
    req_second = 3'b111; cyc();
    chk("R5 unselected dropped", {5'b0, pending}, 8'h00);
    wr_sel(8'h43);
    repeat (2) cyc();
    chk("R5 no replay after switch", {5'b0, pending}, 8'h00);
    req_first = 3'b111; cyc();
    chk("R5 first now unselected", {5'b0, pending}, 8'h00);
    wr_sel(8'h00);
  endtask

  task automatic t_set_wins();
    req_first = 3'b011; ack_clr = 3'b001; sw_clr = 3'b010; cyc();
    chk("R9 set beats clear", {5'b0, pending}, 8'h03);
    req_first = 3'b001; ack_clr = 3'b001; cyc();
    chk("R9 set beats clear while pending", {5'b0, pending}, 8'h03);
  endtask

  task automatic t_sel_change_keeps();
    wr_sel(8'h43);
    chk("R10 pending kept across select write", {5'b0, pending}, 8'h03);
    chk("R2 select written", sel_rdata, 8'h43);
    clear_all();
    chk("R8 final clear", {5'b0, pending}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_register();
    t_select_first();
    t_select_second();
    t_drop();
    t_set_wins();
    t_sel_change_keeps();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule